// File: doc/BRIEF.md
# Exception Frame Record Encoder

This block turns an exception stack frame into a short byte record for logging or for comparison against a reference run. The frame is written byte by byte into an internal frame buffer. A start strobe then supplies the frame length and the frame style. The style is either the short address-fault layout or the layout that carries a format/vector word. The record holds only the fields the rest of the log does not already capture, so the status register copy and the return address are dropped.

A frame that exactly repeats the last stored frame, in both length and every byte, collapses to a single marker byte. Any other frame produces its full record and then becomes the new stored frame. A group-clear pulse invalidates the stored frame at the start of each test group, so the first frame of a group always appears in full.

Records leave on a byte stream with valid/ready flow control. A format code the block does not know raises a one-cycle error pulse instead of producing a record.

Top module: `exc_frame_encoder`

## Requirements
- R1: Every non-marker record begins with a length byte equal to the number of field bytes that follow it, and exactly that many bytes follow.
- R2: With `variant`=0 (short address-fault layout), the fields are frame byte 1 followed by frame bytes 2, 3, 4 and 5 in that order (length byte 5).
- R3: With `variant`=1 (format-word layout), the fields always begin with frame bytes 6 and 7. The format code is bits 7:4 of frame byte 6; bits 3:0 do not affect the selection.
- R4: Format code 0 gives only bytes 6..7 (length 2). Codes 2 and 3 give bytes 6..11 (length 6). Code 8 gives bytes 6..15 (length 10).
- R5: Any other format code on the format-word path emits no byte, pulses `fmt_err` high for one cycle while `busy` is low, and leaves the stored frame unchanged.
- R6: When a valid stored frame exists and the new frame has the same length and identical bytes, the record is the single byte 0xFF.
- R7: A frame that differs from the stored frame in any byte or in its length produces its full record and then replaces the stored frame.
- R8: A `grp_clr` pulse invalidates the stored frame, so the next frame is emitted in full even if it is identical.
- R9: After reset `rec_valid`, `busy` and `fmt_err` are 0 and no frame is stored.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_data` holds its value and no byte is lost or repeated.
- R11: A `start` pulse that arrives while `busy` is high is ignored and produces no extra record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Frame buffer byte write enable |
| wr_addr | input | 8 | Frame buffer byte address |
| wr_data | input | 8 | Frame buffer byte value |
| grp_clr | input | 1 | Invalidate the stored frame (start of a test group) |
| start | input | 1 | Begin encoding the buffered frame (taken only when idle) |
| frame_len | input | 9 | Frame length in bytes, sampled with `start` |
| variant | input | 1 | 0 = short address-fault layout, 1 = format-word layout |
| busy | output | 1 | High while a frame is being processed |
| fmt_err | output | 1 | One-cycle pulse on an unknown format code |
| rec_valid | output | 1 | Record byte available |
| rec_ready | input | 1 | Consumer accepts the record byte |
| rec_data | output | 8 | Record byte |

## Verification
The hardest case to reach is a repeat comparison that fails only on its last byte, or only on length. Such a frame must fall back to a full record and still overwrite the store. The stimulus reaches the first case by resending a stored frame with one byte flipped. It reaches the second by resending the same leading bytes with a longer length. It then resends the frame once more to prove the store took the new copy. A rejected format is followed by the last good frame, whose marker result shows the store was left alone. Random back-pressure and a stray start pulse mid-record exercise the hold and ignore paths.

// File: rtl/efr_pkg.sv
package efr_pkg;

  localparam int unsigned EFR_BW = 8;
  localparam logic [7:0]  EFR_REPEAT_MARK = 8'hFF;

  // field layout positions (decoded downstream, so fixed)
  localparam int unsigned EFR_SHORT_FIRST = 1;
  localparam int unsigned EFR_SHORT_COUNT = 5;
  localparam int unsigned EFR_WORD_FIRST  = 6;
  localparam int unsigned EFR_FMT_POS     = 6;

  localparam logic [3:0]  EFR_FMT_PLAIN   = 4'h0;
  localparam logic [3:0]  EFR_FMT_ADDR    = 4'h2;
  localparam logic [3:0]  EFR_FMT_POST    = 4'h3;
  localparam logic [3:0]  EFR_FMT_FAULT   = 4'h8;

  localparam int unsigned EFR_CNT_PLAIN   = 2;
  localparam int unsigned EFR_CNT_ONELONG = 6;
  localparam int unsigned EFR_CNT_TWOLONG = 10;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMP_RD,
    S_CMP_CHK,
    S_FMT_RD,
    S_FMT_CHK,
    S_FLD_RD,
    S_FLD_PUT,
    S_HOLD,
    S_HOLD_MARK,
    S_CPY_RD,
    S_CPY_WR
  } efr_state_e;

  typedef struct packed {
    logic       bad;
    logic [7:0] first;
    logic [7:0] count;
  } efr_fields_t;

endpackage

// File: rtl/efr_sdp_ram.sv
module efr_sdp_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/efr_field_sel.sv
module efr_field_sel
  import efr_pkg::*;
(
  input  logic        word_fmt,
  input  logic [3:0]  fmt_code,
  output efr_fields_t fields
);

  always_comb begin
    fields.bad   = 1'b0;
    fields.first = 8'(EFR_WORD_FIRST);
    fields.count = 8'(EFR_CNT_PLAIN);
    if (!word_fmt) begin
      fields.first = 8'(EFR_SHORT_FIRST);
      fields.count = 8'(EFR_SHORT_COUNT);
    end else begin
      case (fmt_code)
        EFR_FMT_PLAIN: fields.count = 8'(EFR_CNT_PLAIN);
        EFR_FMT_ADDR,
        EFR_FMT_POST:  fields.count = 8'(EFR_CNT_ONELONG);
        EFR_FMT_FAULT: fields.count = 8'(EFR_CNT_TWOLONG);
        default:       fields.bad   = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/exc_frame_encoder.sv
module exc_frame_encoder
  import efr_pkg::*;
#(
  parameter int unsigned FRAME_DEPTH = 256,
  localparam int unsigned AW = $clog2(FRAME_DEPTH),
  localparam int unsigned LW = $clog2(FRAME_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          grp_clr,
  input  logic          start,
  input  logic [LW-1:0] frame_len,
  input  logic          variant,
  output logic          busy,
  output logic          fmt_err,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [7:0]    rec_data
);

  efr_state_e    state_q;
  logic [LW-1:0] idx_q;
  logic [LW-1:0] len_q;
  logic          var_q;
  logic [7:0]    fcnt_q;
  logic [LW-1:0] fstart_q;
  logic [LW-1:0] prev_len_q;
  logic          prev_ok_q;
  logic          out_valid_q;
  logic [7:0]    out_data_q;
  logic          err_q;

  logic [LW-1:0] rd_idx;
  logic [AW-1:0] rd_addr;
  logic [7:0]    fb_q;
  logic [7:0]    ps_q;
  logic          st_we;
  logic          accept;
  logic          at_last;
  logic          fld_done;
  efr_fields_t   fsel;

  always_comb begin
    case (state_q)
      S_FMT_RD: rd_idx = LW'(EFR_FMT_POS);
      S_FLD_RD: rd_idx = fstart_q + idx_q;
      default:  rd_idx = idx_q;
    endcase
  end

  assign rd_addr  = rd_idx[AW-1:0];
  assign st_we    = (state_q == S_CPY_WR);
  assign accept   = out_valid_q & rec_ready;
  assign at_last  = (idx_q == len_q - LW'(1));
  assign fld_done = (idx_q == LW'(fcnt_q));

  efr_sdp_ram #(.DEPTH(FRAME_DEPTH), .DW(EFR_BW)) u_frame_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (fb_q)
  );

  efr_sdp_ram #(.DEPTH(FRAME_DEPTH), .DW(EFR_BW)) u_prev_store (
    .clk     (clk),
    .wr_en   (st_we),
    .wr_addr (idx_q[AW-1:0]),
    .wr_data (fb_q),
    .rd_addr (rd_addr),
    .rd_data (ps_q)
  );

  efr_field_sel u_sel (
    .word_fmt (var_q),
    .fmt_code (fb_q[7:4]),
    .fields   (fsel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      len_q       <= '0;
      var_q       <= 1'b0;
      fcnt_q      <= '0;
      fstart_q    <= '0;
      prev_len_q  <= '0;
      prev_ok_q   <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            len_q <= frame_len;
            var_q <= variant;
            idx_q <= '0;
            if (prev_ok_q && (frame_len == prev_len_q)) begin
              if (frame_len == '0) begin
                out_data_q  <= EFR_REPEAT_MARK;
                out_valid_q <= 1'b1;
                state_q     <= S_HOLD_MARK;
              end else begin
                state_q <= S_CMP_RD;
              end
            end else begin
              state_q <= S_FMT_RD;
            end
          end
        end
        S_CMP_RD: state_q <= S_CMP_CHK;
        S_CMP_CHK: begin
          if (fb_q != ps_q) begin
            state_q <= S_FMT_RD;
          end else if (at_last) begin
            out_data_q  <= EFR_REPEAT_MARK;
            out_valid_q <= 1'b1;
            state_q     <= S_HOLD_MARK;
          end else begin
            idx_q   <= idx_q + LW'(1);
            state_q <= S_CMP_RD;
          end
        end
        S_FMT_RD: state_q <= S_FMT_CHK;
        S_FMT_CHK: begin
          if (fsel.bad) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            fcnt_q      <= fsel.count;
            fstart_q    <= LW'(fsel.first);
            out_data_q  <= fsel.count;
            out_valid_q <= 1'b1;
            idx_q       <= '0;
            state_q     <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (accept) begin
            out_valid_q <= 1'b0;
            if (!fld_done) begin
              state_q <= S_FLD_RD;
            end else if (len_q == '0) begin
              prev_len_q <= len_q;
              prev_ok_q  <= 1'b1;
              state_q    <= S_IDLE;
            end else begin
              idx_q   <= '0;
              state_q <= S_CPY_RD;
            end
          end
        end
        S_FLD_RD: state_q <= S_FLD_PUT;
        S_FLD_PUT: begin
          out_data_q  <= fb_q;
          out_valid_q <= 1'b1;
          idx_q       <= idx_q + LW'(1);
          state_q     <= S_HOLD;
        end
        S_HOLD_MARK: begin
          if (accept) begin
            out_valid_q <= 1'b0;
            state_q     <= S_IDLE;
          end
        end
        S_CPY_RD: state_q <= S_CPY_WR;
        S_CPY_WR: begin
          if (at_last) begin
            prev_len_q <= len_q;
            prev_ok_q  <= 1'b1;
            state_q    <= S_IDLE;
          end else begin
            idx_q   <= idx_q + LW'(1);
            state_q <= S_CPY_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
      if (grp_clr) begin
        prev_ok_q <= 1'b0;
      end
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign fmt_err   = err_q;
  assign rec_valid = out_valid_q;
  assign rec_data  = out_data_q;

endmodule

// File: rtl/exc_frame_encoder_chk.sv
module exc_frame_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       fmt_err,
  input logic       rec_valid,
  input logic       rec_ready,
  input logic [7:0] rec_data
);

  logic       acc;
  logic       first_q;
  logic [7:0] rem_q;

  assign acc = rec_valid & rec_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      rem_q   <= '0;
    end else if (acc) begin
      if (first_q) begin
        first_q <= 1'b0;
        rem_q   <= (rec_data == 8'hFF) ? 8'd0 : rec_data;
      end else begin
        rem_q <= rem_q - 8'd1;
      end
    end else if (!busy) begin
      first_q <= 1'b1;
    end
  end

  // R1: no byte beyond the announced count
  p_no_excess_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && !first_q) |-> (rem_q != 8'd0));

  // R1: a record is complete when the block goes idle
  p_complete_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (rem_q == 8'd0));

  // R4: only legal length bytes open a record
  p_len_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && first_q && rec_data != 8'hFF) |->
      (rec_data == 8'd2 || rec_data == 8'd5 || rec_data == 8'd6 || rec_data == 8'd10));

  // R10: held byte under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

  // R5: error is a lone pulse with no output
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (!rec_valid && !busy));

  p_err_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> !fmt_err);

  // R9: output only while processing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rec_valid);

endmodule

bind exc_frame_encoder exc_frame_encoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .fmt_err   (fmt_err),
  .rec_valid (rec_valid),
  .rec_ready (rec_ready),
  .rec_data  (rec_data)
);

// File: tb/sim_exc_frame_encoder.sv
`timescale 1ns/1ps
module sim_exc_frame_encoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       grp_clr = 1'b0;
  logic       start = 1'b0;
  logic [8:0] frame_len = '0;
  logic       variant = 1'b0;
  logic       busy, fmt_err, rec_valid;
  logic       rec_ready = 1'b1;
  logic [7:0] rec_data;

  always #4 clk = ~clk;

  exc_frame_encoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .grp_clr(grp_clr), .start(start), .frame_len(frame_len), .variant(variant),
    .busy(busy), .fmt_err(fmt_err), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data)
  );

  int tests = 0;
  int fails = 0;
  int err_seen = 0;
  bit done = 1'b0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] fr [256];
  logic [7:0] pm [256];
  int         pl = 0;
  bit         pok = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rec_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // monitor: a handshake seen here completes at the next rising edge
  always @(negedge clk) begin
    if (!rst && fmt_err) err_seen++;
    if (!rst && rec_valid && rec_ready) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected byte actual %h expected none", rec_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rec_data !== e) begin
          fails++;
          $display("FAIL %s byte actual %h expected %h", t, rec_data, e);
        end
      end
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic fill(input int seed, input int len);
    for (int i = 0; i < len; i++) fr[i] = 8'(seed * 29 + i * 7 + 3);
  endtask

  task automatic group_clear();
    @(negedge clk) grp_clr = 1'b1;
    @(negedge clk) grp_clr = 1'b0;
    pok = 1'b0;
  endtask

  task automatic run_frame(input bit v, input int len, input bit poke, input string tag);
    bit rep;
    bit bad;
    int first;
    int cnt;
    int e0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(i); wr_data = fr[i];
    end
    @(negedge clk) wr_en = 1'b0;
    // model
    rep = pok && (pl == len);
    if (rep) for (int i = 0; i < len; i++) if (pm[i] != fr[i]) rep = 1'b0;
    bad = 1'b0; first = 1; cnt = 5;
    if (v) begin
      first = 6;
      case (fr[6][7:4])
        4'h0: cnt = 2;
        4'h2, 4'h3: cnt = 6;
        4'h8: cnt = 10;
        default: bad = 1'b1;
      endcase
    end
    if (rep) push(8'hFF, tag);
    else if (!bad) begin
      push(8'(cnt), tag);
      for (int k = 0; k < cnt; k++) push(fr[first + k], tag);
      for (int i = 0; i < len; i++) pm[i] = fr[i];
      pl = len; pok = 1'b1;
    end
    e0 = err_seen;
    @(negedge clk);
    start = 1'b1; frame_len = 9'(len); variant = v;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R11 busy before stray start", int'(busy), 1);
      start = 1'b1; variant = ~v; frame_len = 9'd3;
      @(negedge clk) start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk((err_seen - e0) == ((!rep && bad) ? 1 : 0), "R5 error pulses", err_seen - e0,
        (!rep && bad) ? 1 : 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R11 stray start left idle", int'(busy), 0);
    end
    chk(exp_q.size() == 0, "R1 record complete", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rec_valid == 1'b0, "R9 rec_valid after reset", int'(rec_valid), 0);
    chk(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    chk(fmt_err == 1'b0, "R9 fmt_err after reset", int'(fmt_err), 0);

    fill(1, 14);
    run_frame(1'b0, 14, 1'b0, "R2");          // first frame full
    run_frame(1'b0, 14, 1'b0, "R6");          // repeat -> marker
    fr[13] = fr[13] ^ 8'h01;                   // differs only in last byte
    run_frame(1'b0, 14, 1'b0, "R7");
    run_frame(1'b0, 14, 1'b0, "R7 stored");   // now a repeat

    fill(2, 8);  fr[6] = 8'h0C;
    run_frame(1'b1, 8, 1'b0, "R3");
    bp_on = 1'b1;
    fill(3, 12); fr[6] = 8'h2C;
    run_frame(1'b1, 12, 1'b0, "R4 fmt2 R10");
    fill(4, 12); fr[6] = 8'h35;
    run_frame(1'b1, 12, 1'b0, "R4 fmt3 R10");
    fill(5, 18); fr[6] = 8'h80;
    run_frame(1'b1, 16, 1'b0, "R4 fmt8 R10");
    run_frame(1'b1, 16, 1'b0, "R6 fmt8");
    run_frame(1'b1, 18, 1'b0, "R7 length");

    fill(6, 12); fr[6] = 8'h50;
    run_frame(1'b1, 12, 1'b0, "R5");
    fill(5, 18); fr[6] = 8'h80;
    run_frame(1'b1, 18, 1'b0, "R5 store kept");

    group_clear();
    run_frame(1'b1, 18, 1'b0, "R8");

    fill(7, 16); fr[6] = 8'h81;
    run_frame(1'b1, 16, 1'b1, "R11");

    bp_on = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule